// File: doc/BRIEF.md
# Four-Way Replacement Victim Selector

This block holds the replacement state of one four-way set and names the way that the next fill should use. Every access to the set, whether a hit or a fill, arrives as a single-cycle strobe carrying the way index and a flag that marks it as a fill. The block updates two kinds of bookkeeping in parallel: a recency age per way and a saturating use count per way. A mode input then chooses which of the two decides the victim. A tag directory drives the block, or it runs on its own under a test harness. It sees only the way valid bits and the access stream, never tags.

While any way of the set is empty, the victim is the lowest-numbered empty way, whatever the mode. Once all four ways hold data, recency mode evicts the way that has gone longest without an access. Count mode evicts the way with the fewest accesses, and ties go to the lowest way number. A flush, or reset, returns every age and count to zero. With a full set the victim is then way 0 in both modes.

The victim is a combinational function of the registered state, the valid bits and the mode. An access therefore shows up in the victim one clock after its strobe. The selection path decodes into three named sources: PICK_FREE (some way empty), PICK_LRU (full set, recency mode) and PICK_LFU (full set, count mode). The choice is made fresh every cycle. There is no stored transition between the sources: the valid bits and the mode input move the selection from one to another at any time.

Top module: `repl_victim_sel`

## Requirements
- R1: While reset is held, and in the first cycle after it, the victim is way 0 both with all four valid bits set and with none set.
- R2: While any valid bit is clear, the victim is the lowest-numbered way whose valid bit is clear, in either mode and after any history.
- R3: With all ways valid and mode_lfu low, the victim is the way with the oldest most recent access. Ways untouched since the last reset or flush count as older than any accessed way, and ties go to the lowest way number.
- R4: Hits and fills both refresh a way's recency. After fills of ways 0,1,2,3 followed by hits to 1,0,3,2, the recency victim is way 1.
- R5: Each access adds one to that way's use count. With all ways valid and mode_lfu high, the victim is the way with the smallest count, and ties go to the lowest way number.
- R6: After fills of ways 0,1,2,3 followed by 3, 2, 4 and 1 extra hits to ways 0,1,2,3 respectively, the count victim is way 3.
- R7: A fill (acc_fill high) restarts that way's count at 1 and makes it the most recent way, whatever its count was before.
- R8: Use counts are 4 bits wide and stop at 15. A way that has received 17 accesses still counts above a way that has received 3.
- R9: A flush clears all ages and counts and overrides an access in the same cycle. Afterwards a full set gives victim 0 in both modes.
- R10: Both ages and counts are updated in every mode. Changing mode_lfu alone, with no access, switches the victim to the other policy's choice in the next sampled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | One access to the set this cycle |
| acc_way | input | 2 | Way index of the hit or fill |
| acc_fill | input | 1 | The access is a fill that loads a new line |
| way_valid | input | 4 | Valid bit of each way, bit i for way i |
| mode_lfu | input | 1 | 0 selects recency policy, 1 selects use-count policy |
| flush | input | 1 | Clear all replacement state |
| victim | output | 2 | Way index the next fill should use |

## Verification
A wrong age or count is visible on victim one cycle after the access that caused it, but only while the set is full and the matching mode is selected. The bench therefore keeps all four ways valid through most of its run and toggles mode_lfu so that both kinds of state reach the port. It compares victim with a timestamp and counter model every clock. A broken saturation or a broken fill restart stays hidden until the affected way is the smallest or the oldest, so directed histories force those ways into the victim position.

// File: rtl/repl_pkg.sv
`timescale 1ns/1ps
package repl_pkg;
    // Source that decides the victim in the current cycle
    typedef enum logic [1:0] {
        PICK_FREE = 2'd0,
        PICK_LRU  = 2'd1,
        PICK_LFU  = 2'd2
    } pick_src_e;
endpackage

// File: rtl/repl_lru_ages.sv
`timescale 1ns/1ps
module repl_lru_ages #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2,
    parameter int AGE_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic                            acc_vld,
    input  logic [WAY_W-1:0]                acc_way,
    output logic [NUM_WAYS-1:0][AGE_W-1:0]  ages
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [AGE_W-1:0] hit_age;
    assign hit_age = ages[acc_way];

    // Accessed way becomes youngest; every other way at or below its old
    // age grows older by one, stopping at the oldest value.
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                ages[g] <= '0;
            end else if (acc_vld) begin
                if (acc_way == WAY_W'(g)) begin
                    ages[g] <= '0;
                end else if (ages[g] <= hit_age && ages[g] != AGE_MAX) begin
                    ages[g] <= ages[g] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/repl_lfu_counts.sv
`timescale 1ns/1ps
module repl_lfu_counts #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2,
    parameter int CNT_W    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic                            acc_vld,
    input  logic [WAY_W-1:0]                acc_way,
    input  logic                            acc_fill,
    output logic [NUM_WAYS-1:0][CNT_W-1:0]  counts
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                counts[g] <= '0;
            end else if (acc_vld && acc_way == WAY_W'(g)) begin
                if (acc_fill) begin
                    counts[g] <= CNT_ONE;
                end else if (counts[g] != CNT_MAX) begin
                    counts[g] <= counts[g] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/repl_pick.sv
`timescale 1ns/1ps
module repl_pick
    import repl_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2,
    parameter int AGE_W    = 2,
    parameter int CNT_W    = 4
) (
    input  logic                            mode_lfu,
    input  logic [NUM_WAYS-1:0]             way_valid,
    input  logic [NUM_WAYS-1:0][AGE_W-1:0]  ages,
    input  logic [NUM_WAYS-1:0][CNT_W-1:0]  counts,
    output logic [WAY_W-1:0]                victim
);
    pick_src_e        src;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] old_way;
    logic [AGE_W-1:0] old_age;
    logic [WAY_W-1:0] rare_way;
    logic [CNT_W-1:0] rare_cnt;

    // Lowest empty way: scan downwards so the lowest index is written last
    always_comb begin
        free_way = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) free_way = WAY_W'(i);
        end
    end

    // Oldest way, strict compare keeps the lowest index on ties
    always_comb begin
        old_way = '0;
        old_age = ages[0];
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (ages[i] > old_age) begin
                old_way = WAY_W'(i);
                old_age = ages[i];
            end
        end
    end

    // Least used way, strict compare keeps the lowest index on ties
    always_comb begin
        rare_way = '0;
        rare_cnt = counts[0];
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (counts[i] < rare_cnt) begin
                rare_way = WAY_W'(i);
                rare_cnt = counts[i];
            end
        end
    end

    always_comb begin
        if (!(&way_valid))  src = PICK_FREE;
        else if (mode_lfu)  src = PICK_LFU;
        else                src = PICK_LRU;
    end

    always_comb begin
        victim = '0;
        unique case (src)
            PICK_FREE: victim = free_way;
            PICK_LRU:  victim = old_way;
            PICK_LFU:  victim = rare_way;
            default:   victim = '0;
        endcase
    end
endmodule

// File: rtl/repl_victim_sel.sv
`timescale 1ns/1ps
module repl_victim_sel #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 4,
    parameter int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_vld,
    input  logic [WAY_W-1:0]     acc_way,
    input  logic                 acc_fill,
    input  logic [NUM_WAYS-1:0]  way_valid,
    input  logic                 mode_lfu,
    input  logic                 flush,
    output logic [WAY_W-1:0]     victim
);
    localparam int AGE_W = WAY_W;

    logic [NUM_WAYS-1:0][AGE_W-1:0] ages;
    logic [NUM_WAYS-1:0][CNT_W-1:0] counts;

    repl_lru_ages #(
        .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W)
    ) u_ages (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .acc_vld(acc_vld), .acc_way(acc_way), .ages(ages)
    );

    repl_lfu_counts #(
        .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .CNT_W(CNT_W)
    ) u_counts (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .acc_vld(acc_vld), .acc_way(acc_way), .acc_fill(acc_fill),
        .counts(counts)
    );

    repl_pick #(
        .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .AGE_W(AGE_W), .CNT_W(CNT_W)
    ) u_pick (
        .mode_lfu(mode_lfu), .way_valid(way_valid),
        .ages(ages), .counts(counts), .victim(victim)
    );
endmodule

// File: rtl/repl_victim_chk.sv
`timescale 1ns/1ps
module repl_victim_chk #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_vld,
    input logic [WAY_W-1:0]    acc_way,
    input logic                way_valid_full,
    input logic [NUM_WAYS-1:0] way_valid,
    input logic                mode_lfu,
    input logic                flush,
    input logic [WAY_W-1:0]    victim
);
    AST_VICTIM_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(victim)); // R2

    AST_FREE_WAY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !way_valid_full |-> !way_valid[victim]); // R2

    AST_FLUSH_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!way_valid_full || victim == '0)); // R9

    AST_RECENT_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !flush && !mode_lfu) |=>
            (!way_valid_full || mode_lfu || victim != $past(acc_way))); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_vld && !flush) |=>
            (!$stable(way_valid) || !$stable(mode_lfu) || $stable(victim))); // R10
endmodule

bind repl_victim_sel repl_victim_chk #(
    .NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_way(acc_way),
    .way_valid_full(&way_valid), .way_valid(way_valid),
    .mode_lfu(mode_lfu), .flush(flush), .victim(victim)
);

// File: tb/tb_repl_victim_sel.sv
`timescale 1ns/1ps
module tb_repl_victim_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_vld = 1'b0;
    logic [1:0] acc_way = '0;
    logic       acc_fill = 1'b0;
    logic [3:0] way_valid = '0;
    logic       mode_lfu = 1'b0;
    logic       flush = 1'b0;
    logic [1:0] victim;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 1'b0;
    bit done    = 1'b0;

    // Reference model: last-use stamps and saturating counts
    int stamp [4];
    int uses  [4];
    int now_t = 0;

    always #4 clk = ~clk;

    repl_victim_sel dut (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_way(acc_way),
        .acc_fill(acc_fill), .way_valid(way_valid), .mode_lfu(mode_lfu),
        .flush(flush), .victim(victim)
    );

    always @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < 4; i++) begin
                stamp[i] = -1;
                uses[i]  = 0;
            end
        end else if (acc_vld) begin
            stamp[acc_way] = now_t;
            now_t = now_t + 1;
            if (acc_fill)             uses[acc_way] = 1;
            else if (uses[acc_way] < 15) uses[acc_way] = uses[acc_way] + 1;
        end
    end

    function automatic int ref_victim();
        int best;
        if (way_valid != 4'hF) begin
            for (int i = 3; i >= 0; i--) if (!way_valid[i]) best = i;
            return best;
        end
        best = 0;
        for (int i = 1; i < 4; i++) begin
            if (mode_lfu ? (uses[i] < uses[best]) : (stamp[i] < stamp[best]))
                best = i;
        end
        return best;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("[TB] FAIL %s victim=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            if (way_valid != 4'hF) check("R2", int'(victim), ref_victim());
            else if (mode_lfu)     check("R5", int'(victim), ref_victim());
            else                   check("R3", int'(victim), ref_victim());
        end
    end

    task automatic cyc(input logic a, input int w, input logic f, input logic fl);
        @(posedge clk);
        #1;
        acc_vld  = a;
        acc_way  = 2'(w);
        acc_fill = f;
        flush    = fl;
    endtask

    task automatic expect_v(input string req, input int exp);
        cyc(1'b0, 0, 1'b0, 1'b0);
        @(negedge clk);
        check(req, int'(victim), exp);
    endtask

    task automatic fill_all();
        for (int w = 0; w < 4; w++) cyc(1'b1, w, 1'b1, 1'b0);
    endtask

    task automatic hits(input int w, input int n);
        for (int k = 0; k < n; k++) cyc(1'b1, w, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("[TB] FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R1: during reset
        way_valid = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk); check("R1", int'(victim), 0);
        way_valid = 4'h0;
        @(negedge clk); check("R1", int'(victim), 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk); check("R1", int'(victim), 0);
        cmp_on = 1'b1;

        // R2: empty ways filled one by one
        for (int w = 0; w < 4; w++) begin
            @(negedge clk); check("R2", int'(victim), w);
            cyc(1'b1, w, 1'b1, 1'b0);
            way_valid[w] = 1'b1;
        end
        way_valid = 4'b1011;
        expect_v("R2", 2);
        way_valid = 4'hF;

        // R3 / R4: recency order
        cyc(1'b0, 0, 1'b0, 1'b1);
        fill_all();
        expect_v("R3", 0);
        hits(1, 1); hits(0, 1); hits(3, 1); hits(2, 1);
        expect_v("R4", 1);

        // R10: mode change alone switches policy (counts all 2 -> way 0)
        mode_lfu = 1'b1;
        expect_v("R10", 0);
        mode_lfu = 1'b0;
        expect_v("R10", 1);

        // R9: flush overrides a simultaneous access
        cyc(1'b1, 2, 1'b0, 1'b1);
        expect_v("R9", 0);
        mode_lfu = 1'b1;
        expect_v("R9", 0);
        hits(0, 1);
        expect_v("R9", 1);
        mode_lfu = 1'b0;
        expect_v("R9", 1);

        // R6: use-count history
        mode_lfu = 1'b1;
        cyc(1'b0, 0, 1'b0, 1'b1);
        fill_all();
        hits(0, 3); hits(1, 2); hits(2, 4); hits(3, 1);
        expect_v("R6", 3);

        // R7: refill restarts a count
        hits(3, 14);
        expect_v("R7", 1);
        cyc(1'b1, 3, 1'b1, 1'b0);
        expect_v("R7", 3);

        // R8: saturation at 15
        cyc(1'b0, 0, 1'b0, 1'b1);
        fill_all();
        hits(0, 16);
        hits(1, 2); hits(2, 2); hits(3, 2);
        expect_v("R8", 1);

        // Mixed traffic against the model (R2, R3, R5)
        lfsr = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[1:0] != 2'b00, int'(lfsr[3:2]), lfsr[5:4] == 2'b11,
                lfsr[11:6] == 6'd0);
            mode_lfu  = lfsr[12] ^ lfsr[7];
            way_valid = (lfsr[15:13] == 3'd0) ? lfsr[9:6] : 4'hF;
        end
        cyc(1'b0, 0, 1'b0, 1'b0);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule